// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit

This block is a single-cycle multiply-accumulate datapath for a fixed-point signal processing core. On every clock where an operation is issued, it multiplies two 16-bit operands. It then adds the 32-bit product to, or subtracts it from, one of two 40-bit accumulators and writes the result back into that accumulator. The eight bits above the product width act as guard bits, so long sums can grow past 32 bits without wrapping.

Each operand has its own signedness control. This lets the same multiplier form the partial products of extended-precision arithmetic: signed by signed, signed by unsigned, and unsigned by unsigned. A fractional mode doubles the product so that Q15 by Q15 inputs give a Q31 result. The one product that cannot be represented, the most negative value squared, is pinned to the largest positive 32-bit value. Per operation, the caller can also start a fresh sum instead of accumulating, and can ask for the written value to be rounded to the nearest multiple of 2^16.

Top module: `fmac_unit`

## Requirements
- R1: After reset, both accumulators read zero.
- R2: In a cycle where `op_en` is low, neither accumulator changes, whatever the other inputs are.
- R3: `acc_sel` = 0 writes accumulator A and `acc_sel` = 1 writes accumulator B. The unselected accumulator keeps its value.
- R4: `x_signed` and `y_signed` each choose whether their operand is read as two's complement (1) or as unsigned (0). The product is the exact mathematical product of the two values.
- R5: The 40-bit product is sign-extended when either operand is signed and zero-extended when both are unsigned. An unsigned-by-unsigned product therefore never sets bit 39.
- R6: With `sub_en` high, the new value is the old value minus the product. With `sub_en` low, it is the old value plus the product.
- R7: With `clear_en` high, the old value is replaced by zero before the add or subtract. A clear with `sub_en` high therefore loads the negated product.
- R8: With `frac_mode` high, the product is shifted left by one bit before it is used.
- R9: With `frac_mode` high and both operands signed and equal to 0x8000, the product is 0x00_7FFF_FFFF.
- R10: With `round_en` high, 0x8000 is added to the 40-bit result and bits 15:0 are then cleared. Bits 15:0 of the written accumulator are always zero.
- R11: All accumulator arithmetic wraps modulo 2^40. Bits 39:32 hold the growth of the sum.
- R12: An operation issued at a clock edge is visible on the outputs after that edge. Back-to-back operations on the same accumulator chain with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_en | input | 1 | Issue an operation this cycle |
| op_x | input | 16 | First operand |
| op_y | input | 16 | Second operand |
| x_signed | input | 1 | 1: op_x is two's complement |
| y_signed | input | 1 | 1: op_y is two's complement |
| frac_mode | input | 1 | Double the product (Q15 x Q15 to Q31) |
| round_en | input | 1 | Round result to nearest multiple of 2^16 |
| sub_en | input | 1 | Subtract the product instead of adding it |
| clear_en | input | 1 | Use zero instead of the old accumulator value |
| acc_sel | input | 1 | Target accumulator, 0 = A, 1 = B |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |

## Verification
The hardest collision is the fractional pinning of the 0x8000 by 0x8000 product in the same cycle as rounding and subtraction. Getting it right depends on the pinned value being negated first and the rounding bias being applied afterwards. Directed operations put all three controls on one issue, both from a cleared accumulator and on top of a running sum. The random stream also draws each control bit independently, so these combinations recur with random operands. Every result is compared with a bench model that applies the pin, the add or subtract, and then the rounding step in that order.

// File: rtl/fmac_pkg.sv
package fmac_pkg;
  localparam int unsigned OP_W  = 16;
  localparam int unsigned ACC_W = 40;
  localparam int unsigned N_ACC = 2;

  typedef struct packed {
    logic x_s;
    logic y_s;
    logic frac;
    logic rnd;
    logic sub;
    logic clr;
  } fmac_ctrl_t;
endpackage

// File: rtl/fmac_rst_sync.sv
module fmac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/fmac_mult.sv
module fmac_mult #(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 40
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          a_s,
  input  logic          b_s,
  input  logic          frac,
  output logic [AW-1:0] prod
);
  localparam int unsigned PW = 2*W + 2;
  localparam logic [W-1:0]  OP_MIN   = {1'b1, {(W-1){1'b0}}};
  localparam logic [AW-1:0] FRAC_MAX = (AW'(1) << (2*W-1)) - AW'(1);

  logic signed [W:0]    ax, bx;
  logic signed [PW-1:0] p_raw;
  logic [AW-1:0]        p_ext;
  logic                 pin_case;

  always_comb begin
    ax       = {a_s & a[W-1], a};
    bx       = {b_s & b[W-1], b};
    p_raw    = ax * bx;
    p_ext    = {{(AW-PW){p_raw[PW-1]}}, p_raw};
    pin_case = a_s & b_s & (a == OP_MIN) & (b == OP_MIN);
    if (!frac)         prod = p_ext;
    else if (pin_case) prod = FRAC_MAX;
    else               prod = p_ext << 1;
  end
endmodule

// File: rtl/fmac_addrnd.sv
module fmac_addrnd #(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 40
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] prod,
  input  logic          sub,
  input  logic          rnd,
  output logic [AW-1:0] res
);
  localparam logic [AW-1:0] BIAS = AW'(1) << (W-1);

  logic [AW-1:0] sum;
  logic [AW-1:0] biased;

  always_comb begin
    sum    = sub ? (base - prod) : (base + prod);
    biased = sum + BIAS;
    res    = rnd ? {biased[AW-1:W], {W{1'b0}}} : sum;
  end
endmodule

// File: rtl/fmac_accbank.sv
module fmac_accbank #(
  parameter int unsigned AW = 40,
  parameter int unsigned N  = 2,
  localparam int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 we,
  input  logic [SW-1:0]        sel,
  input  logic [AW-1:0]        wdata,
  output logic [AW-1:0]        rdata,
  output logic [N-1:0][AW-1:0] acc
);
  logic [N-1:0][AW-1:0] acc_q, acc_d;
  logic [N-1:0]         en;

  for (genvar i = 0; i < N; i++) begin : g_acc
    always_comb begin
      en[i]    = we && (sel == SW'(i));
      acc_d[i] = en[i] ? wdata : acc_q[i];
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)    acc_q[i] <= '0;
      else if (en[i]) acc_q[i] <= acc_d[i];
    end

    p_hold_unsel_r2_r3: assert property (@(posedge clk) disable iff (!rst_ni)
      !(we && (sel == SW'(i))) |=> $stable(acc_q[i]));
  end

  assign rdata = acc_q[sel];
  assign acc   = acc_q;
endmodule

// File: rtl/fmac_unit.sv
module fmac_unit
  import fmac_pkg::*;
#(
  parameter int unsigned W  = OP_W,
  parameter int unsigned AW = ACC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_en,
  input  logic [W-1:0]  op_x,
  input  logic [W-1:0]  op_y,
  input  logic          x_signed,
  input  logic          y_signed,
  input  logic          frac_mode,
  input  logic          round_en,
  input  logic          sub_en,
  input  logic          clear_en,
  input  logic          acc_sel,
  output logic [AW-1:0] acc_a,
  output logic [AW-1:0] acc_b
);
  fmac_ctrl_t           ctrl;
  logic                 rst_int_n;
  logic [AW-1:0]        prod, base, rd, wr;
  logic [N_ACC-1:0][AW-1:0] acc_all;

  always_comb begin
    ctrl = '{x_s: x_signed, y_s: y_signed, frac: frac_mode,
             rnd: round_en, sub: sub_en, clr: clear_en};
    base = ctrl.clr ? '0 : rd;
  end

  fmac_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_ni(rst_n), .rst_no(rst_int_n)
  );

  fmac_mult #(.W(W), .AW(AW)) u_mult (
    .a(op_x), .b(op_y), .a_s(ctrl.x_s), .b_s(ctrl.y_s),
    .frac(ctrl.frac), .prod(prod)
  );

  fmac_addrnd #(.W(W), .AW(AW)) u_add (
    .base(base), .prod(prod), .sub(ctrl.sub), .rnd(ctrl.rnd), .res(wr)
  );

  fmac_accbank #(.AW(AW), .N(N_ACC)) u_bank (
    .clk(clk), .rst_ni(rst_int_n), .we(op_en), .sel(acc_sel),
    .wdata(wr), .rdata(rd), .acc(acc_all)
  );

  assign acc_a = acc_all[0];
  assign acc_b = acc_all[1];

  p_uu_nonneg_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!x_signed && !y_signed) |-> !prod[AW-1]);

  p_frac_square_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (frac_mode && x_signed && y_signed && op_x == op_y) |-> !prod[AW-1]);

  p_clear_load_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_en && clear_en && !round_en && !sub_en && !acc_sel) |=> acc_a == $past(prod));

  p_round_low_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_en && round_en && acc_sel) |=> acc_b[W-1:0] == '0);
endmodule

// File: tb/test_fmac_unit.sv
`timescale 1ns/1ps
module test_fmac_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_en, x_signed, y_signed, frac_mode, round_en, sub_en, clear_en, acc_sel;
  logic [15:0] op_x, op_y;
  logic [39:0] acc_a, acc_b;
  logic [39:0] exp_a, exp_b;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  fmac_unit i_fmac_unit (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_x(op_x), .op_y(op_y),
    .x_signed(x_signed), .y_signed(y_signed), .frac_mode(frac_mode),
    .round_en(round_en), .sub_en(sub_en), .clear_en(clear_en),
    .acc_sel(acc_sel), .acc_a(acc_a), .acc_b(acc_b)
  );

  function automatic logic [39:0] model_prod(logic [15:0] x, logic [15:0] y,
                                             logic xs, logic ys, logic fr);
    longint vx, vy, p;
    vx = xs ? longint'($signed(x)) : longint'(x);
    vy = ys ? longint'($signed(y)) : longint'(y);
    p  = vx * vy;
    if (fr) begin
      if (xs && ys && x == 16'h8000 && y == 16'h8000) p = 64'h7FFF_FFFF;
      else p = p * 2;
    end
    return p[39:0];
  endfunction

  function automatic logic [39:0] model_next(logic [39:0] old, logic [39:0] p,
                                             logic sb, logic cl, logic rd);
    logic [39:0] b, r;
    b = cl ? 40'h0 : old;
    r = sb ? b - p : b + p;
    if (rd) r = (r + 40'h8000) & ~40'hFFFF;
    return r;
  endfunction

  task automatic chk(string req, logic [39:0] got, logic [39:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_op(logic en, logic [15:0] x, logic [15:0] y, logic xs, logic ys,
                       logic fr, logic rd, logic sb, logic cl, logic sel, string req);
    logic [39:0] p;
    op_en = en; op_x = x; op_y = y; x_signed = xs; y_signed = ys;
    frac_mode = fr; round_en = rd; sub_en = sb; clear_en = cl; acc_sel = sel;
    p = model_prod(x, y, xs, ys, fr);
    if (en) begin
      if (sel) exp_b = model_next(exp_b, p, sb, cl, rd);
      else     exp_a = model_next(exp_a, p, sb, cl, rd);
    end
    @(negedge clk);
    chk({req, " acc_a"}, acc_a, exp_a);
    chk({req, " acc_b"}, acc_b, exp_b);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    op_en = 1'b0; op_x = '0; op_y = '0; x_signed = 0; y_signed = 0;
    frac_mode = 0; round_en = 0; sub_en = 0; clear_en = 0; acc_sel = 0;
    exp_a = '0; exp_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset acc_a", acc_a, 40'h0);
    chk("R1 reset acc_b", acc_b, 40'h0);

    // R4 signed by signed, R3 write to A only
    do_op(1, 16'hFFFF, 16'hFFFF, 1, 1, 0, 0, 0, 0, 0, "R4 R3 ss -1*-1");
    chk("R4 acc_a value", acc_a, 40'h1);
    // R5 signed by unsigned sign-extended, into B
    do_op(1, 16'hFFFF, 16'hFFFF, 1, 0, 0, 0, 0, 1, 1, "R5 su");
    chk("R5 sign-extended", acc_b, 40'hFF_FFFF_0001);
    // R5 unsigned by unsigned zero-extended, R7 clear
    do_op(1, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 0, 1, 0, "R5 R7 uu clear");
    chk("R5 zero-extended", acc_a, 40'h00_FFFE_0001);
    // R9 pinned fractional square
    do_op(1, 16'h8000, 16'h8000, 1, 1, 1, 0, 0, 1, 1, "R9 pin");
    chk("R9 value", acc_b, 40'h00_7FFF_FFFF);
    // R8 fractional doubling
    do_op(1, 16'h4000, 16'h4000, 1, 1, 1, 0, 0, 1, 0, "R8 frac");
    chk("R8 value", acc_a, 40'h00_2000_0000);
    // R6 subtract
    do_op(1, 16'h0003, 16'h0005, 1, 1, 0, 0, 1, 0, 0, "R6 sub");
    chk("R6 value", acc_a, 40'h00_1FFF_FFF1);
    // R7 clear with subtract loads negated product
    do_op(1, 16'h0002, 16'h0003, 0, 0, 0, 0, 1, 1, 1, "R7 clear sub");
    chk("R7 negated", acc_b, 40'hFF_FFFF_FFFA);
    // R10 rounding up at half and down below half
    do_op(1, 16'h0001, 16'h8000, 0, 0, 0, 1, 0, 1, 0, "R10 half");
    chk("R10 half up", acc_a, 40'h00_0001_0000);
    do_op(1, 16'h0001, 16'h7FFF, 0, 0, 0, 1, 0, 1, 1, "R10 below");
    chk("R10 below half", acc_b, 40'h0);
    // pinned product, subtract and round in one cycle
    do_op(1, 16'h8000, 16'h8000, 1, 1, 1, 1, 1, 1, 0, "R9 R6 R10 combo");
    chk("R10 combo value", acc_a, 40'hFF_8000_0000);
    do_op(1, 16'h8000, 16'h8000, 1, 1, 1, 1, 1, 0, 0, "R9 R6 R10 combo acc");
    // R2 idle cycles with busy inputs
    for (int i = 0; i < 20; i++)
      do_op(0, 16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R2 idle");
    // R11 guard growth and wrap, R12 back-to-back on one accumulator
    do_op(1, 16'hFFFF, 16'hFFFF, 0, 0, 1, 0, 0, 1, 1, "R11 start");
    for (int i = 0; i < 140; i++)
      do_op(1, 16'hFFFF, 16'hFFFF, 0, 0, 1, 0, 0, 0, 1, "R11 R12 grow");
    // random stream
    for (int i = 0; i < 3000; i++)
      do_op(($urandom % 8) != 0, 16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 6) == 0,
            1'($urandom), "R3 R4 R6 R12 random");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule